// File: doc/BRIEF.md
# Single-Wire Bus Slot Timer

This block times the individual slots on a single-wire, open-drain data line. A controller above it asks for one slot at a time: a bus reset with presence detection, a write-0 slot, a write-1 slot or a read slot. The block pulls the line low for the right time and lets it go. For reads and resets it samples the line at a fixed point. It signals the end of the slot with a single-cycle done pulse. The line is modelled as a drive-low enable that feeds an external open-drain pad, plus the level read back from that pad.

All timing is counted in microsecond ticks from a clock prescaler. A slot's durations are set in microseconds by parameters, and each one is multiplied by a runtime coefficient that the controller supplies with the request. This lets software slow the whole protocol down on a heavily loaded or long line. Byte framing and command sequencing belong to the controller and are not part of this block.

Top module: `ow_slot_engine`

## Requirements
- R1: After reset, busy, done, drive_low, rx_bit and present are all 0.
- R2: Slot code 2'b10 is a write-1 slot. The line is driven low for 6 units, and done rises 70 units after the slot is accepted. One unit is coef x CLK_PER_US clock cycles.
- R3: Slot code 2'b01 is a write-0 slot. The line is driven low for 60 units, and done rises 70 units after acceptance.
- R4: Slot code 2'b11 is a read slot. The line is driven low for 6 units. The line is sampled once, at the end of a 9-unit wait after release, and that level becomes rx_bit. Done rises 70 units after acceptance.
- R5: Slot code 2'b00 is a bus reset. The line is driven low for 500 units, and the line is sampled 70 units after release. Present becomes 1 if the sample is low and 0 if it is high. A further 430 units of recovery follow, so done rises 1000 units after acceptance.
- R6: The coefficient is captured when a slot is accepted. A value of 0 is treated as 1, and changing it during a slot has no effect on that slot.
- R7: A start request is accepted only while busy is 0. A start that arrives during a slot is ignored: the running slot keeps its type, its timing and its result.
- R8: Busy is 1 from the cycle after acceptance until the cycle in which done is 1. Done is high for exactly one cycle, and busy is 0 in that cycle.
- R9: Write slots change neither rx_bit nor present. A read slot leaves present unchanged, and a reset slot leaves rx_bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Slot request strobe, sampled while idle |
| slot_kind | input | 2 | Slot type: 00 reset, 01 write-0, 10 write-1, 11 read |
| coef | input | COEF_W | Delay stretch factor, 0 treated as 1 |
| line_in | input | 1 | Level read back from the line |
| drive_low | output | 1 | Pull the line low when 1 |
| busy | output | 1 | A slot is in progress |
| done | output | 1 | One-cycle pulse at the end of a slot |
| rx_bit | output | 1 | Level captured by the last read slot |
| present | output | 1 | Presence result of the last reset slot |

## Verification
Suppose the phase state or the tick count goes wrong. The first sign at the ports is a low pulse of the wrong length on drive_low, within one unit of the fault. The next sign is done arriving at the wrong cycle, so the bench counts both to the exact cycle for every slot type and for several coefficients. A wrongly captured coefficient or slot type only shows when the slot ends: the total length is off, or the result bit sits on the wrong output. A lost sample shows as an unchanged rx_bit or present after done. Starts fired in the middle of a slot, with the coefficient changed at the same time, check that none of this leaks into a slot that is already running.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;

   typedef enum logic [1:0] {
      SLOT_RESET = 2'b00,
      SLOT_WR0   = 2'b01,
      SLOT_WR1   = 2'b10,
      SLOT_READ  = 2'b11
   } slot_kind_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_LOW   = 2'd1,
      PH_SAMP  = 2'd2,
      PH_RECOV = 2'd3
   } phase_e;

endpackage

// File: rtl/ow_us_prescaler.sv
module ow_us_prescaler #(
   parameter int CLK_PER_US = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   output logic tick
);
   localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

   generate
      if (CLK_PER_US == 1) begin : g_every_cycle
         assign tick = run;
      end else begin : g_divide
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (clear) begin
               pre_q <= '0;
            end else if (run) begin
               if (pre_q == PW'(CLK_PER_US - 1)) pre_q <= '0;
               else                              pre_q <= pre_q + 1'b1;
            end
         end
         assign tick = run && (pre_q == PW'(CLK_PER_US - 1));
      end
   endgenerate

endmodule

// File: rtl/ow_phase_timer.sv
module ow_phase_timer #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (tick)   cnt_q <= cnt_q + 1'b1;
   end

   assign expire = tick && (cnt_q == (limit - 1'b1));

endmodule

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic synced
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign synced = raw;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= {sh_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], raw} & {STAGES{1'b1}};
         end
         assign synced = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ow_slot_seq.sv
module ow_slot_seq
   import ow_slot_pkg::*;
#(
   parameter int US_W       = 10,
   parameter int COEF_W     = 4,
   parameter int CNT_W      = 14,
   parameter int T_W1_LOW   = 6,
   parameter int T_W1_REC   = 64,
   parameter int T_W0_LOW   = 60,
   parameter int T_W0_REC   = 10,
   parameter int T_RD_LOW   = 6,
   parameter int T_RD_SAMP  = 9,
   parameter int T_RD_REC   = 55,
   parameter int T_RST_LOW  = 500,
   parameter int T_RST_SAMP = 70,
   parameter int T_RST_REC  = 430
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        slot_kind,
   input  logic [COEF_W-1:0] coef,
   input  logic              line_s,
   input  logic              expire,
   output logic              phase_clear,
   output logic              run,
   output logic [CNT_W-1:0]  limit,
   output logic              drive_low,
   output logic              busy,
   output logic              done,
   output logic              rx_bit,
   output logic              present
);
   phase_e            phase_q;
   slot_kind_e        kind_q;
   logic [COEF_W-1:0] coef_q;
   logic              accept;
   logic [US_W-1:0]   low_us, samp_us, rec_us, cur_us;

   assign accept = (phase_q == PH_IDLE) && start;

   always_comb begin
      unique case (kind_q)
         SLOT_RESET: begin low_us = US_W'(T_RST_LOW); samp_us = US_W'(T_RST_SAMP); rec_us = US_W'(T_RST_REC); end
         SLOT_WR0:   begin low_us = US_W'(T_W0_LOW);  samp_us = '0;                rec_us = US_W'(T_W0_REC);  end
         SLOT_WR1:   begin low_us = US_W'(T_W1_LOW);  samp_us = '0;                rec_us = US_W'(T_W1_REC);  end
         default:    begin low_us = US_W'(T_RD_LOW);  samp_us = US_W'(T_RD_SAMP);  rec_us = US_W'(T_RD_REC);  end
      endcase
      unique case (phase_q)
         PH_LOW:   cur_us = low_us;
         PH_SAMP:  cur_us = samp_us;
         PH_RECOV: cur_us = rec_us;
         default:  cur_us = '1;
      endcase
      limit = CNT_W'(cur_us) * CNT_W'(coef_q);
   end

   assign phase_clear = accept || expire;
   assign run         = (phase_q != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         kind_q    <= SLOT_RESET;
         coef_q    <= COEF_W'(1);
         drive_low <= 1'b0;
         busy      <= 1'b0;
         done      <= 1'b0;
         rx_bit    <= 1'b0;
         present   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            phase_q   <= PH_LOW;
            kind_q    <= slot_kind_e'(slot_kind);
            coef_q    <= (coef == '0) ? COEF_W'(1) : coef;
            drive_low <= 1'b1;
            busy      <= 1'b1;
         end else if (expire) begin
            unique case (phase_q)
               PH_LOW: begin
                  drive_low <= 1'b0;
                  phase_q   <= (samp_us != '0) ? PH_SAMP : PH_RECOV;
               end
               PH_SAMP: begin
                  phase_q <= PH_RECOV;
                  if (kind_q == SLOT_READ)  rx_bit  <= line_s;
                  if (kind_q == SLOT_RESET) present <= ~line_s;
               end
               PH_RECOV: begin
                  phase_q <= PH_IDLE;
                  busy    <= 1'b0;
                  done    <= 1'b1;
               end
               default: phase_q <= PH_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine #(
   parameter int CLK_PER_US  = 50,
   parameter int COEF_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int US_W        = 10,
   parameter int T_W1_LOW    = 6,
   parameter int T_W1_REC    = 64,
   parameter int T_W0_LOW    = 60,
   parameter int T_W0_REC    = 10,
   parameter int T_RD_LOW    = 6,
   parameter int T_RD_SAMP   = 9,
   parameter int T_RD_REC    = 55,
   parameter int T_RST_LOW   = 500,
   parameter int T_RST_SAMP  = 70,
   parameter int T_RST_REC   = 430
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        slot_kind,
   input  logic [COEF_W-1:0] coef,
   input  logic              line_in,
   output logic              drive_low,
   output logic              busy,
   output logic              done,
   output logic              rx_bit,
   output logic              present
);
   localparam int CNT_W = US_W + COEF_W;

   if (CLK_PER_US < 1) begin : g_chk_pre
      $error("CLK_PER_US must be at least 1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_chk_sync
      $error("SYNC_STAGES must lie in 0..4");
   end
   if (T_RST_LOW >= (1 << US_W) || T_W1_REC >= (1 << US_W) || T_RST_REC >= (1 << US_W)) begin : g_chk_w
      $error("slot timing does not fit in US_W bits");
   end
   if (T_W1_LOW < 1 || T_W0_LOW < 1 || T_RD_LOW < 1 || T_RST_LOW < 1 ||
       T_RD_SAMP < 1 || T_RST_SAMP < 1 || T_W1_REC < 1 || T_W0_REC < 1 ||
       T_RD_REC < 1 || T_RST_REC < 1) begin : g_chk_pos
      $error("every slot phase must last at least one microsecond");
   end

   logic             line_s;
   logic             tick, expire, phase_clear, run;
   logic [CNT_W-1:0] limit;

   ow_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw(line_in), .synced(line_s)
   );

   ow_us_prescaler #(.CLK_PER_US(CLK_PER_US)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .clear(phase_clear), .tick(tick)
   );

   ow_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(phase_clear), .tick(tick),
      .limit(limit), .expire(expire)
   );

   ow_slot_seq #(
      .US_W(US_W), .COEF_W(COEF_W), .CNT_W(CNT_W),
      .T_W1_LOW(T_W1_LOW), .T_W1_REC(T_W1_REC),
      .T_W0_LOW(T_W0_LOW), .T_W0_REC(T_W0_REC),
      .T_RD_LOW(T_RD_LOW), .T_RD_SAMP(T_RD_SAMP), .T_RD_REC(T_RD_REC),
      .T_RST_LOW(T_RST_LOW), .T_RST_SAMP(T_RST_SAMP), .T_RST_REC(T_RST_REC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .slot_kind(slot_kind),
      .coef(coef), .line_s(line_s), .expire(expire),
      .phase_clear(phase_clear), .run(run), .limit(limit),
      .drive_low(drive_low), .busy(busy), .done(done),
      .rx_bit(rx_bit), .present(present)
   );

endmodule

// File: rtl/ow_slot_engine_chk.sv
module ow_slot_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic drive_low,
   input logic busy,
   input logic done,
   input logic rx_bit,
   input logic present
);
   // R8: the end-of-slot pulse lasts a single cycle
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: busy has already fallen when done is seen
   a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R1: the line is never pulled while no slot runs
   a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !drive_low);

   // R7: a new low pulse only begins from an accepted request while idle
   a_r7_drive_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_low) |-> ($past(start) && !$past(busy)));

   // R4: the read result moves only during the released part of a slot
   a_r4_rx_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_bit) |-> (busy && !drive_low));

   // R5: the presence result moves only during the released part of a slot
   a_r5_present_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(present) |-> (busy && !drive_low));

endmodule

bind ow_slot_engine ow_slot_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .drive_low(drive_low),
   .busy(busy), .done(done), .rx_bit(rx_bit), .present(present)
);

// File: tb/ow_slot_engine_tb.sv
module ow_slot_engine_tb;
   localparam int P      = 2;
   localparam int COEF_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [1:0] slot_kind = 2'b00;
   logic [COEF_W-1:0] coef = '0;
   logic level = 1'b1;
   logic line_in;
   logic drive_low, busy, done, rx_bit, present;

   int total = 0;
   int bad = 0;
   logic m_rx = 1'b0;
   logic m_pres = 1'b0;

   always #10 clk = ~clk;

   assign line_in = drive_low ? 1'b0 : level;

   ow_slot_engine #(.CLK_PER_US(P), .COEF_W(COEF_W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .slot_kind(slot_kind),
      .coef(coef), .line_in(line_in), .drive_low(drive_low), .busy(busy),
      .done(done), .rx_bit(rx_bit), .present(present)
   );

   typedef struct packed {
      logic [1:0]  kind;
      logic [3:0]  cf;
      logic        lvl;
      logic [10:0] low_us;
      logic [10:0] tot_us;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{2'b00, 4'd1, 1'b0, 11'd500, 11'd1000},
      '{2'b11, 4'd1, 1'b1, 11'd6,   11'd70},
      '{2'b10, 4'd1, 1'b0, 11'd6,   11'd70},
      '{2'b01, 4'd3, 1'b0, 11'd60,  11'd70},
      '{2'b11, 4'd2, 1'b0, 11'd6,   11'd70},
      '{2'b00, 4'd2, 1'b1, 11'd500, 11'd1000},
      '{2'b11, 4'd0, 1'b1, 11'd6,   11'd70},
      '{2'b10, 4'd5, 1'b1, 11'd6,   11'd70}
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [1:0] k);
      case (k)
         2'b00:   return "R5";
         2'b01:   return "R3";
         2'b10:   return "R2";
         default: return "R4";
      endcase
   endfunction

   // Runs one slot; inject=1 fires a second start with another type and coefficient mid-slot (R7, R6)
   task automatic run_slot(input vec_t v, input bit inject);
      int eff, lowc, n, exp_low, exp_tot;
      string rq;
      rq = req_of(v.kind);
      eff = (v.cf == 0) ? 1 : int'(v.cf);
      exp_low = int'(v.low_us) * eff * P;
      exp_tot = int'(v.tot_us) * eff * P;
      level = v.lvl;
      @(negedge clk);
      slot_kind = v.kind;
      coef = v.cf;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      lowc = 0;
      check("R8", "busy after accept", int'(busy), 1);
      while (!done && n < exp_tot + 50) begin
         if (drive_low) lowc++;
         if (inject && n == 10) begin
            start = 1'b1;
            slot_kind = ~v.kind;
            coef = v.cf + 4'd3;
         end
         if (inject && n == 11) start = 1'b0;
         if (inject && n == exp_low + 3) begin
            start = 1'b1;
            slot_kind = 2'b00;
         end
         if (inject && n == exp_low + 4) start = 1'b0;
         @(negedge clk);
         n++;
      end
      check(rq, "low cycles", lowc, exp_low);
      check(rq, "cycles to done", n, exp_tot + 1);
      check("R8", "busy low with done", int'(busy), 0);
      if (v.kind == 2'b11) m_rx = v.lvl;
      if (v.kind == 2'b00) m_pres = ~v.lvl;
      check((v.kind == 2'b11) ? "R4" : "R9", "rx_bit", int'(rx_bit), int'(m_rx));
      check((v.kind == 2'b00) ? "R5" : "R9", "present", int'(present), int'(m_pres));
      @(negedge clk);
      check("R8", "done one cycle", int'(done), 0);
   endtask

   initial begin
      #(20 * 190000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "busy", int'(busy), 0);
      check("R1", "done", int'(done), 0);
      check("R1", "drive_low", int'(drive_low), 0);
      check("R1", "rx_bit", int'(rx_bit), 0);
      check("R1", "present", int'(present), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", "busy after release", int'(busy), 0);

      for (int i = 0; i < NV; i++) run_slot(VEC[i], 1'b0);

      // R7 / R6: mid-slot starts and coefficient changes ignored (read, level 0)
      run_slot('{2'b11, 4'd2, 1'b0, 11'd6, 11'd70}, 1'b1);
      // R7 / R6: same on a write-0 slot, results must stay put (R9)
      run_slot('{2'b01, 4'd1, 1'b1, 11'd60, 11'd70}, 1'b1);
      // R6: coefficient 0 behaves as 1 on a reset with a device present
      run_slot('{2'b00, 4'd0, 1'b0, 11'd500, 11'd1000}, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule